// File: doc/BRIEF.md
# LCD Two-Phase Segment Multiplexer and Backplane Generator

This block drives a 1:2 multiplexed liquid-crystal panel from a bank of latched segment data. Each display position owns a pair of bits, one for each of the two backplanes. The block divides the multiplex clock into two control signals. A phase signal runs at half the clock rate and picks which bit of every pair reaches the segment line. An inversion signal runs at a quarter of the rate and flips the drive polarity, so that the glass sees no DC component.

The same two signals set the two backplane lines. Each backplane carries one of three drive levels, given here as 2-bit codes for a later analog stage. In each phase exactly one backplane is active. The other one rests at the middle level. The segment outputs are combinational from the latched data and the registered divider. They therefore follow a change in the data without waiting for a clock edge.

Top module: `lcd_seg_mux`

## Requirements
- R1: A synchronous `rst` sampled high at a rising edge of `clk` clears the divider, so that `com` and `m` are both 0 after that edge.
- R2: With `rst` low, `com` inverts at every rising edge of `clk`, giving half the clock rate.
- R3: With `rst` low, `m` inverts at a rising edge exactly when `com` was 1 before that edge, giving a quarter of the clock rate.
- R4: While `com` is 0, `seg_out[n]` equals `seg_bits[2n] ^ m`. Bit 2n is the first bit of pair n.
- R5: While `com` is 1, `seg_out[n]` equals `seg_bits[2n+1] ^ m`. Bit 2n+1 is the second bit of pair n.
- R6: `bp1` is active while `com` is 0 and sits at the middle code 2'b01 while `com` is 1.
- R7: `bp2` is active while `com` is 1 and sits at the middle code 2'b01 while `com` is 0.
- R8: An active backplane carries the low code 2'b00 when `m` is 0 and the high code 2'b10 when `m` is 1. The code 2'b11 never appears on either backplane.
- R9: At every instant exactly one of `bp1` and `bp2` is at the middle code.
- R10: A change on `seg_bits` reaches `seg_out` within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Multiplex clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_bits | input | 2*NSEG | Latched segment pairs; bit 2n is the first bit and bit 2n+1 the second bit of pair n |
| seg_out | output | NSEG | Multiplexed, polarity-adjusted segment drive bits |
| com | output | 1 | Phase signal at half the clock rate |
| m | output | 1 | Inversion signal at a quarter of the clock rate |
| bp1 | output | 2 | First backplane level code (00 low, 01 mid, 10 high) |
| bp2 | output | 2 | Second backplane level code (00 low, 01 mid, 10 high) |

## Verification
The bench drives data patterns that set only the first bits of each pair, only the second bits, or bits that differ from pair to pair. A design with the pair order swapped, or with a polarity flip left out in one half of the period, would then show a visibly wrong segment vector. It walks through the whole four-state period, so that an inversion signal tied to the wrong divider bit would change polarity at the wrong time, and an active level with the wrong sense would show up on the backplane codes. It also applies a reset in the middle of a period, which catches a divider that clears only one of its two bits. Finally it changes the data between clock edges, which catches an output stage that has been registered by mistake.

// File: rtl/lcd_seg_mux.sv
module lcd_seg_mux #(
  parameter int NSEG = 140
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*NSEG-1:0] seg_bits,
  output logic [NSEG-1:0]   seg_out,
  output logic              com,
  output logic              m,
  output logic [1:0]        bp1,
  output logic [1:0]        bp2
);
  localparam logic [1:0] LV_LO  = 2'b00;
  localparam logic [1:0] LV_MID = 2'b01;
  localparam logic [1:0] LV_HI  = 2'b10;

  logic [1:0] phase;
  logic [1:0] active_lv;

  always_ff @(posedge clk) begin
    if (rst) phase <= 2'b00;
    else     phase <= phase + 2'd1;
  end

  assign com       = phase[0];
  assign m         = phase[1];
  assign active_lv = m ? LV_HI : LV_LO;
  assign bp1       = com ? LV_MID : active_lv;
  assign bp2       = com ? active_lv : LV_MID;

  for (genvar n = 0; n < NSEG; n++) begin : g_seg
    assign seg_out[n] = (com ? seg_bits[2*n+1] : seg_bits[2*n]) ^ m;
  end
endmodule

module lcd_seg_mux_chk #(
  parameter int NSEG = 140
) (
  input logic              clk,
  input logic              rst,
  input logic [2*NSEG-1:0] seg_bits,
  input logic [NSEG-1:0]   seg_out,
  input logic              com,
  input logic              m,
  input logic [1:0]        bp1,
  input logic [1:0]        bp2
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!com && !m)); // R1
  AST_COM_FLIPS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (com != $past(com))); // R2
  AST_M_QUARTER: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((m != $past(m)) == $past(com))); // R3
  AST_BP1_PHASE: assert property (@(posedge clk) disable iff (rst)
    (bp1 != 2'b01) == !com); // R6
  AST_BP2_PHASE: assert property (@(posedge clk) disable iff (rst)
    (bp2 != 2'b01) == com); // R7
  AST_NO_CODE11: assert property (@(posedge clk) disable iff (rst)
    (bp1 != 2'b11) && (bp2 != 2'b11)); // R8
  AST_ONE_MID: assert property (@(posedge clk) disable iff (rst)
    $countones({bp1 == 2'b01, bp2 == 2'b01}) == 1); // R9
endmodule

bind lcd_seg_mux lcd_seg_mux_chk #(.NSEG(NSEG)) u_chk (
  .clk(clk), .rst(rst), .seg_bits(seg_bits), .seg_out(seg_out),
  .com(com), .m(m), .bp1(bp1), .bp2(bp2)
);

// File: tb/lcd_seg_mux_test.sv
module lcd_seg_mux_test;
  localparam int NSEG = 140;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2*NSEG-1:0] seg_bits = '0;
  logic [NSEG-1:0]   seg_out;
  logic              com, m;
  logic [1:0]        bp1, bp2;

  int k = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  lcd_seg_mux #(.NSEG(NSEG)) uut (
    .clk(clk), .rst(rst), .seg_bits(seg_bits), .seg_out(seg_out),
    .com(com), .m(m), .bp1(bp1), .bp2(bp2)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [NSEG-1:0] act,
                       input logic [NSEG-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst) k++;
    #3;
  endtask

  function automatic logic [NSEG-1:0] exp_seg(input logic [2*NSEG-1:0] b, input int kk);
    logic [NSEG-1:0] r;
    for (int n = 0; n < NSEG; n++)
      r[n] = (kk[0] ? b[2*n+1] : b[2*n]) ^ kk[1];
    return r;
  endfunction

  function automatic logic [1:0] exp_bp(input bit first, input int kk);
    if (kk[0] == first) return 2'b01;
    return kk[1] ? 2'b10 : 2'b00;
  endfunction

  task automatic check_state(input string ctx);
    logic [NSEG-1:0] es;
    logic [1:0] e1, e2;
    es = exp_seg(seg_bits, k);
    e1 = exp_bp(1'b1, k);
    e2 = exp_bp(1'b0, k);
    check(com == k[0], {"R2 com ", ctx}, NSEG'(com), NSEG'(k[0]));
    check(m == k[1], {"R3 m ", ctx}, NSEG'(m), NSEG'(k[1]));
    check(seg_out == es, k[0] ? {"R5 seg ", ctx} : {"R4 seg ", ctx}, seg_out, es);
    check(bp1 == e1, {"R6 bp1 ", ctx}, NSEG'(bp1), NSEG'(e1));
    check(bp2 == e2, {"R7 bp2 ", ctx}, NSEG'(bp2), NSEG'(e2));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step();
    step();
    k = 0;
    check(!com && !m, "R1 divider after reset", NSEG'({com, m}), '0);
    check(bp1 == 2'b00 && bp2 == 2'b01, "R8 reset levels", NSEG'({bp1, bp2}), NSEG'(4'b0001));
    rst = 1'b0;
  endtask

  task automatic t_divider();
    seg_bits = '0;
    for (int i = 0; i < 8; i++) begin
      step();
      check_state("divider sweep");
    end
  endtask

  task automatic t_patterns();
    logic [2*NSEG-1:0] pats [5];
    logic [31:0] lf;
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = {NSEG{2'b01}};
    pats[3] = {NSEG{2'b10}};
    lf = 32'hACE1_1234;
    for (int i = 0; i < 2*NSEG; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      pats[4][i] = lf[0];
    end
    for (int p = 0; p < 5; p++) begin
      seg_bits = pats[p];
      for (int i = 0; i < 4; i++) begin
        step();
        check_state("pattern");
      end
    end
  endtask

  task automatic t_backplane();
    for (int i = 0; i < 4; i++) begin
      step();
      check((bp1 != 2'b11) && (bp2 != 2'b11), "R8 no code 11", NSEG'({bp1, bp2}), '0);
      check((bp1 == 2'b01) != (bp2 == 2'b01), "R9 one mid", NSEG'({bp1, bp2}), '0);
      check((k[0] ? bp2 : bp1) == (k[1] ? 2'b10 : 2'b00), "R8 active level",
            NSEG'(k[0] ? bp2 : bp1), NSEG'(k[1] ? 2'b10 : 2'b00));
    end
  endtask

  task automatic t_live_data();
    logic [NSEG-1:0] es;
    for (int i = 0; i < 4; i++) begin
      step();
      seg_bits = {NSEG{2'b01}} ^ {{(2*NSEG-8){1'b0}}, 8'hC3};
      #1;
      es = exp_seg(seg_bits, k);
      check(seg_out == es, "R10 same-cycle data A", seg_out, es);
      seg_bits = ~seg_bits;
      #1;
      es = exp_seg(seg_bits, k);
      check(seg_out == es, "R10 same-cycle data B", seg_out, es);
    end
  endtask

  task automatic t_mid_reset();
    seg_bits = {NSEG{2'b10}};
    step();
    step();
    step();
    rst = 1'b1;
    step();
    k = 0;
    check(!com && !m, "R1 mid-period reset", NSEG'({com, m}), '0);
    rst = 1'b0;
    step();
    check_state("after mid reset");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #3;
    t_reset();
    t_divider();
    t_patterns();
    t_backplane();
    t_live_data();
    t_mid_reset();
    finish_run();
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule